// File: doc/BRIEF.md
# Segmented Address Translation Checker

The block turns a logical address, made of a 16-bit segment selector and an offset, into a linear address. It also decides whether the access is allowed. In real mode it shifts the segment value left by four and adds the low 16 bits of the offset. The result is 20 bits wide and no protection checks are made. In protected mode the caller supplies a descriptor that has already been loaded into a 64-bit cache register. From that descriptor the block takes the base, the limit, the type bits and the privilege level. It then checks the selector, the descriptor type, the privilege, the present bit and the segment limit before it adds the base to the offset.

A request is presented for one cycle with `req_valid` high. The verdict appears on the registered outputs in the next cycle, marked by `rsp_valid`. A refused access reports a fault vector and an error code that holds the selector with its two privilege bits cleared. Faults on the stack segment report the stack-fault vector in place of the other fault vectors.

The controller has two states, `ST_IDLE` and `ST_RESP`, and three transitions:
- ACCEPT (`ST_IDLE` to `ST_RESP`) is taken when a request arrives.
- STREAM (`ST_RESP` to `ST_RESP`) is taken on a back-to-back request.
- DRAIN (`ST_RESP` to `ST_IDLE`) is taken when no request follows.

Top module: `seg_xlate_unit`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. After reset all outputs are 0. The outputs keep their last values while no request arrives.
- R2: With `prot_mode`=0 the block adds `{seg_sel,4'h0}` to `offset[15:0]`, keeps the low 20 bits of the sum as `lin_addr`, and drives bits 31:20 to 0. `rsp_ok` is 1 whatever the other inputs are.
- R3: The selector fields are: index in bits 15:3, table flag in bit 2, requested privilege (RPL) in bits 1:0. In protected mode, index 0 with table flag 0 is a null selector. This check has the highest priority. It faults with vector 13 (12 on the stack segment) and error code 0.
- R4: The descriptor fields are: base = {d[63:56], d[39:32], d[31:16]}; raw limit = {d[51:48], d[15:0]}; G d[55]; D/B d[54]; P d[47]; DPL d[46:45]; S d[44]; TYPE d[43:40]. Bits 53:52 are ignored. A descriptor with S=0 faults with vector 13 and error code `seg_sel & 16'hFFFC`.
- R5: Type rules. TYPE bit 3 = 1 marks code, and bit 1 is then the readable flag. TYPE bit 3 = 0 marks data, and bit 1 is then the writable flag. An execute access (`acc_kind`=2) needs code. A write (`acc_kind`=1) to code faults. A write to data needs the writable flag. A read (`acc_kind` 0 or 3) of code needs the readable flag. Each of these faults uses vector 13 and the selector error code.
- R6: Privilege rules. The effective level is the larger of CPL and RPL. Data reads and writes fault when the effective level is above DPL, and so do reads of non-conforming code (TYPE bit 2 = 0). A read of conforming code skips this check. Executing non-conforming code requires CPL equal to DPL. Executing conforming code requires CPL not below DPL. Each of these faults uses vector 13 and the selector error code.
- R7: A descriptor with P=0 that passes R3 to R6 faults with vector 11 (12 on the stack segment) and the selector error code.
- R8: With G=1 the effective limit is `{raw_limit, 12'hFFF}`. With G=0 it is the raw limit, zero-extended.
- R9: For code segments and for data with TYPE bit 2 = 0, the access faults when its last byte lies past the effective limit. That byte is `offset + size - 1`, worked out without wrap. The fault uses vector 13 and error code 0.
- R10: For data with TYPE bit 2 = 1 (expand-down), an offset at or below the limit faults. The access also faults when its last byte lies past the top, which is 0xFFFF when D/B=0 and 0xFFFFFFFF when D/B=1. The fault uses vector 13 and error code 0.
- R11: With `stack_seg`=1, every protected-mode fault reports vector 12.
- R12: An allowed protected access gives `lin_addr` = (base + offset) mod 2^32. Allowed accesses report `fault_vec` and `fault_err` as 0. Refused accesses report `lin_addr` as 0.
- R13: `acc_size` gives the access width: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| prot_mode | input | 1 | 1 = protected, 0 = real mode |
| seg_sel | input | 16 | Segment selector or real-mode segment value |
| offset | input | 32 | Offset within the segment |
| desc | input | 64 | Cached segment descriptor |
| cpl | input | 2 | Current privilege level |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| acc_size | input | 2 | Access width code |
| stack_seg | input | 1 | Access goes through the stack segment |
| rsp_valid | output | 1 | Result valid |
| rsp_ok | output | 1 | Access allowed |
| lin_addr | output | 32 | Linear address |
| fault_vec | output | 8 | Fault vector (11, 12 or 13) |
| fault_err | output | 16 | Error code |

## Verification
The bound checker runs on every cycle. It checks:
- the one-cycle response timing and the quiet, stable outputs between requests;
- that real mode is always accepted and stays within 20 bits;
- that null selectors, absent descriptors and data-privilege violations are refused;
- that stack faults use only vector 12;
- that allowed and refused verdicts are encoded cleanly.

Only the bench scenarios can show that the exact address sums, the fault priority order, the limit boundaries under page granularity, the expand-down bounds with both top values, and the width codes give the right values.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEL_W      = 16;
    localparam int ADDR_W     = 32;
    localparam int DESC_W     = 64;
    localparam int RAW_LIM_W  = 20;
    localparam int PAGE_SHIFT = ADDR_W - RAW_LIM_W;
    localparam int SMALL_TOP_W = 16;
    localparam int VEC_W      = 8;

    localparam logic [VEC_W-1:0] VEC_NOT_PRESENT = 8'd11;
    localparam logic [VEC_W-1:0] VEC_STACK       = 8'd12;
    localparam logic [VEC_W-1:0] VEC_GEN_PROT    = 8'd13;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xlate_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              big;
        logic              present;
        logic [1:0]        dpl;
        logic              is_seg;
        logic [3:0]        typ;
    } seg_fields_t;

endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_xlate_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output seg_fields_t       fields
);

    logic [RAW_LIM_W-1:0] raw_lim;
    logic                 gran;
    logic                 unused_desc_bits;

    // bits 53:52 carry no meaning for this checker
    assign unused_desc_bits = ^desc[53:52];

    assign raw_lim = {desc[51:48], desc[15:0]};
    assign gran    = desc[55];

    always_comb begin
        fields.base    = {desc[63:56], desc[39:32], desc[31:16]};
        fields.big     = desc[54];
        fields.present = desc[47];
        fields.dpl     = desc[46:45];
        fields.is_seg  = desc[44];
        fields.typ     = desc[43:40];
        if (gran) begin
            fields.limit = {raw_lim, {PAGE_SHIFT{1'b1}}};
        end else begin
            fields.limit = {{PAGE_SHIFT{1'b0}}, raw_lim};
        end
    end

endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
    import seg_xlate_pkg::*;
(
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] limit,
    input  logic              expand_down,
    input  logic              big,
    input  logic [1:0]        size_code,
    output logic              limit_fault
);

    localparam int EXT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] span;
    logic [EXT_W-1:0]  last_byte;
    logic [EXT_W-1:0]  top;

    always_comb begin
        unique case (size_code)
            2'd0:    span = ADDR_W'(0);
            2'd1:    span = ADDR_W'(1);
            default: span = ADDR_W'(3);
        endcase
    end

    assign last_byte = {1'b0, offset} + {1'b0, span};

    generate
        if (SMALL_TOP_W < ADDR_W) begin : g_two_tops
            assign top = big ? {1'b0, {ADDR_W{1'b1}}}
                             : {{(EXT_W-SMALL_TOP_W){1'b0}}, {SMALL_TOP_W{1'b1}}};
        end else begin : g_one_top
            assign top = {1'b0, {ADDR_W{1'b1}}};
        end
    endgenerate

    always_comb begin
        if (expand_down) begin
            limit_fault = (offset <= limit) || (last_byte > top);
        end else begin
            limit_fault = last_byte > {1'b0, limit};
        end
    end

endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
    import seg_xlate_pkg::*;
(
    input  logic [3:0] typ,
    input  logic [1:0] dpl,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    input  acc_kind_e  kind,
    output logic       access_fault
);

    logic       is_code;
    logic       conf_or_down;
    logic       rd_or_wr_ok;
    logic [1:0] eff_pl;
    logic       data_pl_bad;

    assign is_code      = typ[3];
    assign conf_or_down = typ[2];
    assign rd_or_wr_ok  = typ[1];
    assign eff_pl       = (cpl > rpl) ? cpl : rpl;
    assign data_pl_bad  = eff_pl > dpl;

    always_comb begin
        access_fault = 1'b0;
        unique case (kind)
            ACC_EXEC: begin
                if (!is_code) begin
                    access_fault = 1'b1;
                end else if (conf_or_down) begin
                    access_fault = cpl < dpl;
                end else begin
                    access_fault = cpl != dpl;
                end
            end
            ACC_WRITE: begin
                access_fault = is_code || !rd_or_wr_ok || data_pl_bad;
            end
            ACC_READ, ACC_RSVD: begin
                if (is_code) begin
                    access_fault = !rd_or_wr_ok || (!conf_or_down && data_pl_bad);
                end else begin
                    access_fault = data_pl_bad;
                end
            end
        endcase
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int REAL_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              prot_mode,
    input  logic [SEL_W-1:0]  seg_sel,
    input  logic [ADDR_W-1:0] offset,
    input  logic [DESC_W-1:0] desc,
    input  logic [1:0]        cpl,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_size,
    input  logic              stack_seg,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [ADDR_W-1:0] lin_addr,
    output logic [VEC_W-1:0]  fault_vec,
    output logic [SEL_W-1:0]  fault_err
);

    localparam int REAL_W = SEL_W + REAL_SHIFT;

    xlate_state_e state_q, state_d;

    seg_fields_t        fld;
    logic               access_fault;
    logic               limit_fault;
    logic [REAL_W-1:0]  real_sum;
    logic               sel_null;
    logic [SEL_W-1:0]   sel_err;
    logic [VEC_W-1:0]   gp_vec;
    logic [VEC_W-1:0]   np_vec;

    logic               nx_ok;
    logic [ADDR_W-1:0]  nx_lin;
    logic [VEC_W-1:0]   nx_vec;
    logic [SEL_W-1:0]   nx_err;

    seg_desc_unpack u_unpack (
        .desc   (desc),
        .fields (fld)
    );

    seg_access_chk u_access (
        .typ          (fld.typ),
        .dpl          (fld.dpl),
        .cpl          (cpl),
        .rpl          (seg_sel[1:0]),
        .kind         (acc_kind_e'(acc_kind)),
        .access_fault (access_fault)
    );

    seg_limit_chk u_limit (
        .offset      (offset),
        .limit       (fld.limit),
        .expand_down (!fld.typ[3] && fld.typ[2]),
        .big         (fld.big),
        .size_code   (acc_size),
        .limit_fault (limit_fault)
    );

    assign real_sum = {seg_sel, {REAL_SHIFT{1'b0}}} + REAL_W'(offset[SEL_W-1:0]);
    assign sel_null = (seg_sel[SEL_W-1:3] == '0) && !seg_sel[2];
    assign sel_err  = {seg_sel[SEL_W-1:2], 2'b00};
    assign gp_vec   = stack_seg ? VEC_STACK : VEC_GEN_PROT;
    assign np_vec   = stack_seg ? VEC_STACK : VEC_NOT_PRESENT;

    // verdict in fixed priority order
    always_comb begin
        nx_ok  = 1'b1;
        nx_lin = '0;
        nx_vec = '0;
        nx_err = '0;
        if (!prot_mode) begin
            nx_lin = ADDR_W'(real_sum);
        end else if (sel_null) begin
            nx_ok  = 1'b0;
            nx_vec = gp_vec;
        end else if (!fld.is_seg || access_fault) begin
            nx_ok  = 1'b0;
            nx_vec = gp_vec;
            nx_err = sel_err;
        end else if (!fld.present) begin
            nx_ok  = 1'b0;
            nx_vec = np_vec;
            nx_err = sel_err;
        end else if (limit_fault) begin
            nx_ok  = 1'b0;
            nx_vec = gp_vec;
        end else begin
            nx_lin = fld.base + offset;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ACCEPT, STREAM, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ok    <= 1'b0;
            lin_addr  <= '0;
            fault_vec <= '0;
            fault_err <= '0;
        end else if (req_valid) begin
            rsp_ok    <= nx_ok;
            lin_addr  <= nx_lin;
            fault_vec <= nx_vec;
            fault_err <= nx_err;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva
    import seg_xlate_pkg::*;
#(
    parameter int REAL_SHIFT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              prot_mode,
    input logic [SEL_W-1:0]  seg_sel,
    input logic [1:0]        cpl,
    input logic              stack_seg,
    input logic              d_present,
    input logic              d_seg,
    input logic              d_code,
    input logic [1:0]        d_dpl,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic [ADDR_W-1:0] lin_addr,
    input logic [VEC_W-1:0]  fault_vec,
    input logic [SEL_W-1:0]  fault_err
);

    localparam int REAL_W = SEL_W + REAL_SHIFT;

    logic       is_null;
    logic [1:0] eff_pl;

    assign is_null = (seg_sel[SEL_W-1:3] == '0) && !seg_sel[2];
    assign eff_pl  = (cpl > seg_sel[1:0]) ? cpl : seg_sel[1:0];

    assert_resp_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(lin_addr) && $stable(rsp_ok)
                        && $stable(fault_vec) && $stable(fault_err)));

    assert_real_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode) |=> (rsp_ok && (lin_addr >> REAL_W) == '0));

    assert_null_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_mode && is_null) |=>
            (!rsp_ok && fault_err == '0
             && (fault_vec == VEC_GEN_PROT || fault_vec == VEC_STACK)));

    assert_data_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_mode && !is_null && d_seg && !d_code && eff_pl > d_dpl)
            |=> !rsp_ok);

    assert_absent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_mode && !is_null && !d_present) |=> !rsp_ok);

    assert_stack_vec_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_mode && stack_seg) |=> (rsp_ok || fault_vec == VEC_STACK));

    assert_ok_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> (fault_vec == '0 && fault_err == '0));

    assert_fault_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |->
            (lin_addr == '0 && (fault_vec == VEC_NOT_PRESENT
             || fault_vec == VEC_STACK || fault_vec == VEC_GEN_PROT)));

endmodule

bind seg_xlate_unit seg_xlate_sva #(.REAL_SHIFT(REAL_SHIFT)) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .prot_mode (prot_mode),
    .seg_sel   (seg_sel),
    .cpl       (cpl),
    .stack_seg (stack_seg),
    .d_present (desc[47]),
    .d_seg     (desc[44]),
    .d_code    (desc[43]),
    .d_dpl     (desc[46:45]),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .lin_addr  (lin_addr),
    .fault_vec (fault_vec),
    .fault_err (fault_err)
);

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        prot_mode = 1'b0;
    logic [15:0] seg_sel = '0;
    logic [31:0] offset = '0;
    logic [63:0] desc = '0;
    logic [1:0]  cpl = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_size = '0;
    logic        stack_seg = 1'b0;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [31:0] lin_addr;
    logic [7:0]  fault_vec;
    logic [15:0] fault_err;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    seg_xlate_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_mode(prot_mode),
        .seg_sel(seg_sel), .offset(offset), .desc(desc), .cpl(cpl),
        .acc_kind(acc_kind), .acc_size(acc_size), .stack_seg(stack_seg),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .lin_addr(lin_addr),
        .fault_vec(fault_vec), .fault_err(fault_err)
    );

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
        input logic g, input logic db, input logic p, input logic [1:0] dpl,
        input logic s, input logic [3:0] typ);
        return {base[31:24], g, db, 2'b00, lim[19:16], p, dpl, s, typ,
                base[23:16], base[15:0], lim[15:0]};
    endfunction

    task automatic model(input logic pm, input logic [15:0] sel, input logic [31:0] off,
        input logic [63:0] d, input logic [1:0] cl, input logic [1:0] kind,
        input logic [1:0] sz, input logic stk,
        output logic ok, output logic [7:0] vec, output logic [15:0] err,
        output logic [31:0] lin, output string tag);
        logic [19:0] rs;
        logic [31:0] base, lim, top;
        logic [32:0] last;
        logic [3:0]  typ;
        logic [1:0]  dpl, epl;
        logic        tf, pf, down;
        logic [7:0]  gp;
        ok = 1'b1; vec = '0; err = '0; lin = '0; tag = "R12";
        gp = stk ? 8'd12 : 8'd13;
        if (!pm) begin
            rs = {sel, 4'h0} + {4'h0, off[15:0]};
            lin = {12'h0, rs};
            tag = "R2";
            return;
        end
        base = {d[63:56], d[39:32], d[31:16]};
        lim  = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'h0, d[51:48], d[15:0]};
        typ  = d[43:40];
        dpl  = d[46:45];
        epl  = (cl > sel[1:0]) ? cl : sel[1:0];
        tf = 1'b0; pf = 1'b0;
        if (kind == 2'd2) begin
            if (!typ[3]) tf = 1'b1;
            else if (typ[2]) pf = cl < dpl;
            else pf = cl != dpl;
        end else if (kind == 2'd1) begin
            if (typ[3] || !typ[1]) tf = 1'b1;
            else pf = epl > dpl;
        end else begin
            if (typ[3]) begin
                if (!typ[1]) tf = 1'b1;
                else if (!typ[2]) pf = epl > dpl;
            end else pf = epl > dpl;
        end
        last = {1'b0, off} + ((sz == 2'd0) ? 33'd0 : (sz == 2'd1) ? 33'd1 : 33'd3);
        down = !typ[3] && typ[2];
        top  = d[54] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        if (sel[15:3] == 0 && !sel[2]) begin
            ok = 0; vec = gp; tag = stk ? "R11" : "R3";
        end else if (!d[44]) begin
            ok = 0; vec = gp; err = {sel[15:2], 2'b00}; tag = "R4";
        end else if (tf || pf) begin
            ok = 0; vec = gp; err = {sel[15:2], 2'b00}; tag = tf ? "R5" : "R6";
        end else if (!d[47]) begin
            ok = 0; vec = stk ? 8'd12 : 8'd11; err = {sel[15:2], 2'b00}; tag = "R7";
        end else if (down ? (off <= lim || last > {1'b0, top}) : (last > {1'b0, lim})) begin
            ok = 0; vec = gp; tag = down ? "R10" : (d[55] ? "R8" : "R9");
        end else begin
            lin = base + off;
        end
    endtask

    // one request; response checked at the following falling edge
    task automatic apply(input logic pm, input logic [15:0] sel, input logic [31:0] off,
        input logic [63:0] d, input logic [1:0] cl, input logic [1:0] kind,
        input logic [1:0] sz, input logic stk, input string req);
        logic e_ok; logic [7:0] e_vec; logic [15:0] e_err; logic [31:0] e_lin;
        string tag;
        model(pm, sel, off, d, cl, kind, sz, stk, e_ok, e_vec, e_err, e_lin, tag);
        if (req != "") tag = req;
        prot_mode = pm; seg_sel = sel; offset = off; desc = d; cpl = cl;
        acc_kind = kind; acc_size = sz; stack_seg = stk; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_vec++;
        if (rsp_valid !== 1'b1 || rsp_ok !== e_ok || fault_vec !== e_vec
            || fault_err !== e_err || lin_addr !== e_lin) begin
            n_bad++;
            $display("FAIL %s: got v=%b ok=%b vec=%0d err=%h lin=%h, expected v=1 ok=%b vec=%0d err=%h lin=%h",
                     tag, rsp_valid, rsp_ok, fault_vec, fault_err, lin_addr,
                     e_ok, e_vec, e_err, e_lin);
        end
    endtask

    // R1: an idle cycle drops rsp_valid and leaves outputs untouched
    task automatic idle_check();
        logic [31:0] l0; logic ok0;
        l0 = lin_addr; ok0 = rsp_ok;
        @(negedge clk);
        n_vec++;
        if (rsp_valid !== 1'b0 || lin_addr !== l0 || rsp_ok !== ok0) begin
            n_bad++;
            $display("FAIL R1: idle got v=%b lin=%h ok=%b, expected v=0 lin=%h ok=%b",
                     rsp_valid, lin_addr, rsp_ok, l0, ok0);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL R1: watchdog expired, got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] dd;
        int unsigned seed;
        seed = $urandom(32'd20511);
        repeat (3) @(negedge clk);
        // R1 reset state
        n_vec++;
        if (rsp_valid !== 1'b0 || rsp_ok !== 1'b0 || lin_addr !== 32'h0 || fault_vec !== 8'h0) begin
            n_bad++;
            $display("FAIL R1: reset got v=%b ok=%b lin=%h vec=%0d, expected all zero",
                     rsp_valid, rsp_ok, lin_addr, fault_vec);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 real mode, wrap at 20 bits and upper offset ignored
        apply(0, 16'hFFFF, 32'h0000_FFFF, '0, 2'd3, 2'd1, 2'd2, 0, "R2");
        apply(0, 16'h1234, 32'hABCD_0010, '1, 2'd3, 2'd2, 2'd0, 1, "R2");
        idle_check();
        // R3 null selector, R11 on stack, table-flag index 0 is not null
        dd = mk_desc(32'h1000, 20'hFFFFF, 0, 1, 1, 2'd3, 1, 4'b0010);
        apply(1, 16'h0003, 32'h10, dd, 2'd0, 2'd0, 2'd0, 0, "R3");
        apply(1, 16'h0002, 32'h10, dd, 2'd0, 2'd0, 2'd0, 1, "R11");
        apply(1, 16'h0007, 32'h10, dd, 2'd0, 2'd0, 2'd0, 0, "R3");
        // R4 system descriptor
        apply(1, 16'h0013, 32'h10, mk_desc(0, 20'hFF, 0, 1, 1, 2'd3, 0, 4'b0010),
              2'd0, 2'd0, 2'd0, 0, "R4");
        // R5 type rules
        apply(1, 16'h0010, 32'h10, dd, 2'd0, 2'd2, 2'd0, 0, "R5");
        apply(1, 16'h0010, 32'h10, mk_desc(0, 20'hFF, 0, 1, 1, 2'd0, 1, 4'b1010),
              2'd0, 2'd1, 2'd0, 0, "R5");
        apply(1, 16'h0010, 32'h10, mk_desc(0, 20'hFF, 0, 1, 1, 2'd0, 1, 4'b1000),
              2'd0, 2'd3, 2'd0, 0, "R5");
        apply(1, 16'h0010, 32'h10, mk_desc(0, 20'hFF, 0, 1, 1, 2'd3, 1, 4'b0000),
              2'd0, 2'd1, 2'd0, 0, "R5");
        // R6 privilege
        apply(1, 16'h0013, 32'h10, mk_desc(0, 20'hFF, 0, 1, 1, 2'd2, 1, 4'b0010),
              2'd0, 2'd0, 2'd0, 0, "R6");
        apply(1, 16'h0010, 32'h10, mk_desc(0, 20'hFF, 0, 1, 1, 2'd0, 1, 4'b1110),
              2'd3, 2'd2, 2'd0, 0, "R6");
        apply(1, 16'h0010, 32'h10, mk_desc(0, 20'hFF, 0, 1, 1, 2'd0, 1, 4'b1010),
              2'd3, 2'd2, 2'd0, 0, "R6");
        // R7 not present, stack variant
        apply(1, 16'h0021, 32'h10, mk_desc(0, 20'hFF, 0, 1, 0, 2'd3, 1, 4'b0010),
              2'd1, 2'd0, 2'd0, 0, "R7");
        apply(1, 16'h0021, 32'h10, mk_desc(0, 20'hFF, 0, 1, 0, 2'd3, 1, 4'b0010),
              2'd1, 2'd0, 2'd0, 1, "R11");
        // R8 R9 R13 page-granular limit 0x1FFF
        dd = mk_desc(32'h4000_0000, 20'h00001, 1, 1, 1, 2'd3, 1, 4'b0010);
        apply(1, 16'h0008, 32'h1FFF, dd, 2'd0, 2'd0, 2'd0, 0, "R8");
        apply(1, 16'h0008, 32'h1FFF, dd, 2'd0, 2'd0, 2'd1, 0, "R13");
        apply(1, 16'h0008, 32'h1FFE, dd, 2'd0, 2'd0, 2'd1, 0, "R9");
        apply(1, 16'h0008, 32'h1FFC, dd, 2'd0, 2'd0, 2'd3, 0, "R13");
        apply(1, 16'h0008, 32'h1FFD, dd, 2'd0, 2'd0, 2'd2, 0, "R13");
        // R10 expand-down
        dd = mk_desc(32'h0, 20'h000FF, 0, 0, 1, 2'd3, 1, 4'b0110);
        apply(1, 16'h0008, 32'hFF, dd, 2'd0, 2'd1, 2'd0, 0, "R10");
        apply(1, 16'h0008, 32'h100, dd, 2'd0, 2'd1, 2'd0, 0, "R10");
        apply(1, 16'h0008, 32'hFFFF, dd, 2'd0, 2'd0, 2'd0, 0, "R10");
        apply(1, 16'h0008, 32'hFFFE, dd, 2'd0, 2'd0, 2'd2, 0, "R10");
        dd = mk_desc(32'h0, 20'h000FF, 0, 1, 1, 2'd3, 1, 4'b0110);
        apply(1, 16'h0008, 32'hFFFF_FFFC, dd, 2'd0, 2'd0, 2'd2, 0, "R10");
        apply(1, 16'h0008, 32'hFFFF_FFFD, dd, 2'd0, 2'd0, 2'd2, 0, "R10");
        // R12 base plus offset wraps
        apply(1, 16'h0008, 32'h2000, mk_desc(32'hFFFF_F000, 20'hFFFFF, 1, 1, 1, 2'd3, 1, 4'b0010),
              2'd0, 2'd0, 2'd0, 0, "R12");
        idle_check();

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] rl; logic g; logic [31:0] el, off; logic [15:0] sel;
            rl  = 20'($urandom % 20'h20000);
            g   = $urandom % 4 == 0;
            dd  = {$urandom, $urandom};
            dd[51:48] = rl[19:16]; dd[15:0] = rl[15:0]; dd[55] = g;
            dd[47] = ($urandom % 8) != 0;
            dd[44] = ($urandom % 8) != 0;
            el  = g ? {rl, 12'hFFF} : {12'h0, rl};
            off = ($urandom % 3 == 0) ? $urandom : el + 32'($urandom % 8) - 32'd4;
            sel = 16'($urandom);
            if ($urandom % 16 == 0) sel[15:2] = '0;
            apply(($urandom % 8) != 0, sel, off, dd, 2'($urandom), 2'($urandom),
                  2'($urandom), ($urandom % 4) == 0, "");
            if (i % 97 == 0) idle_check();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule